// File: doc/BRIEF.md
# Multi-Channel Transceiver Control and Status Register Block

This block is the software-facing register file of a multi-channel serial transceiver. A management processor reaches it over a 32-bit word-addressed slave port with separate read and write strobes and a wait-request handshake. Through it, software picks which channels respond to digital resets. It can fire self-clearing TX or RX digital reset commands, or hold individual reset lines asserted for as long as it wants. It also drives the per-channel serial loopback and CDR lock-mode controls, and reads back the CDR lock status.

The PCS side is reached through an indirect channel selector. Software writes a channel number once. After that, a status word, a counter word and a counter-clear word all refer to that channel. Each channel keeps a saturating BER counter and a saturating errored-block counter. It also keeps two sticky flags: one records any high-BER episode and one records any loss of block lock. A read of the counter word re-arms both flags. The reset sequencer, the analog front end and the PCS datapath sit outside this block. They connect only through status inputs, count-increment pulses and the gated reset outputs.

Top module: `xcvr_ctl_regs`

## Requirements
- R1: Every access (read or write strobe high) sees `cfg_wait` high in its first cycle and low in its second. The access takes effect at the first clock edge. Read data is valid while `cfg_wait` is low.
- R2: Word 0x041 is a read-write channel mask that comes out of reset as all ones. Bit n enables channel n for digital resets.
- R3: A write to word 0x042 with bit 0 set drives `tx_dig_rst_o` high on the masked channels for `PULSE_CYC` cycles, counting from the edge that accepts the write. Bit 1 does the same for `rx_dig_rst_o`. The command bits clear themselves.
- R4: A read of word 0x042 returns `tx_ready_i` in bit 0 and `rx_ready_i` in bit 1, with all other bits 0. It never returns the command that was written.
- R5: Word 0x044 holds three reset controls: bit 1 TX digital, bit 2 RX analog and bit 3 RX digital. Each stays asserted until 0 is written. All other bits read 0.
- R6: Each reset output for channel n equals (command pulse OR held bit) AND mask bit n. The RX analog reset comes from the held bit alone. A mask change takes effect at once.
- R7: Words 0x061 (loopback), 0x064 (lock to data) and 0x065 (lock to reference) are read-write vectors that drive their outputs, with bit n for channel n, and reset to 0. Words 0x066 and 0x067 read `lock_data_i` and `lock_ref_i`, and writes to them are ignored.
- R8: Word 0x080 is write-only: it stores the channel selector and reads 0. Word 0x082 returns the selected channel's status in this bit order: link-up 0, high-BER 1, block-lock 2, TX FIFO full 3, RX FIFO full 4, sync-header error 5, scrambler error 6, RX data ready 7.
- R9: Word 0x083 bit 14 is a sticky copy of high-BER that sets on any assertion. Bit 15 is a sticky copy of block-lock that clears on any loss of lock. A read of 0x083 returns the sticky values and then reloads both flags with the live inputs. Both flags reset to 0.
- R10: Word 0x083 bits [5:0] hold the BER count and bits [13:6] hold the errored-block count of the selected channel. Both counters saturate at all ones. Writing 1 to bit 2 of word 0x081 clears the errored-block counter, and bit 3 clears the BER counter. A clear overrides an increment in the same cycle.
- R11: An access to an unmapped word returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_addr | input | 9 | Word address |
| cfg_wdata | input | 32 | Write data |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 32 | Read data |
| cfg_wait | output | 1 | Wait request |
| tx_ready_i | input | 1 | TX ready from the reset sequencer |
| rx_ready_i | input | 1 | RX ready from the reset sequencer |
| lock_data_i | input | NUM_CH | CDR locked to data, per channel |
| lock_ref_i | input | NUM_CH | CDR locked to reference, per channel |
| link_up_i | input | NUM_CH | PCS link up |
| hi_ber_i | input | NUM_CH | High BER |
| blk_lock_i | input | NUM_CH | Block lock |
| txf_full_i | input | NUM_CH | TX FIFO full |
| rxf_full_i | input | NUM_CH | RX FIFO full |
| sync_err_i | input | NUM_CH | Sync-header error |
| scr_err_i | input | NUM_CH | Scrambler error |
| rx_dready_i | input | NUM_CH | RX data ready |
| ber_inc_i | input | NUM_CH | BER count increment pulse |
| err_inc_i | input | NUM_CH | Errored-block count increment pulse |
| loopback_o | output | NUM_CH | Serial loopback enable |
| set_ltd_o | output | NUM_CH | CDR lock-to-data request |
| set_ltr_o | output | NUM_CH | CDR lock-to-reference request |
| tx_dig_rst_o | output | NUM_CH | Gated TX digital reset |
| rx_ana_rst_o | output | NUM_CH | Gated RX analog reset |
| rx_dig_rst_o | output | NUM_CH | Gated RX digital reset |

## Verification
Each access is accepted at the first rising edge after the strobes rise. Register outputs, counters, sticky flags and the reset pulse therefore change right after that edge. Read data is due in the second cycle, when `cfg_wait` has dropped, so the bench samples it at the falling edge of that cycle. A reset pulse first shows on the falling edge after the completing edge. It stays high for `PULSE_CYC` edges counted from the accepting edge, so the bench samples it two falling edges later and again one edge after that. Counter and flag stimuli are driven on falling edges, which lets each clock edge count exactly one sample.

// File: rtl/xcvr_ctl_pkg.sv
package xcvr_ctl_pkg;
  localparam int ADDR_W = 9;

  localparam logic [ADDR_W-1:0] A_MASK     = 9'h041;
  localparam logic [ADDR_W-1:0] A_RST_CMD  = 9'h042;
  localparam logic [ADDR_W-1:0] A_RST_HOLD = 9'h044;
  localparam logic [ADDR_W-1:0] A_LOOP     = 9'h061;
  localparam logic [ADDR_W-1:0] A_LTD      = 9'h064;
  localparam logic [ADDR_W-1:0] A_LTR      = 9'h065;
  localparam logic [ADDR_W-1:0] A_LTD_ST   = 9'h066;
  localparam logic [ADDR_W-1:0] A_LTR_ST   = 9'h067;
  localparam logic [ADDR_W-1:0] A_CH_SEL   = 9'h080;
  localparam logic [ADDR_W-1:0] A_CNT_CLR  = 9'h081;
  localparam logic [ADDR_W-1:0] A_PCS_ST   = 9'h082;
  localparam logic [ADDR_W-1:0] A_PCS_CNT  = 9'h083;

  // bit positions inside the hold word
  localparam int HB_TXD = 1;
  localparam int HB_RXA = 2;
  localparam int HB_RXD = 3;

  // bit positions inside the counter-clear word
  localparam int CB_ERR = 2;
  localparam int CB_BER = 3;
endpackage

// File: rtl/xcvr_ctl_bus.sv
module xcvr_ctl_bus (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_i,
  input  logic wr_i,
  output logic wait_o,
  output logic rd_go_o,
  output logic wr_go_o
);
  logic ack_q;
  logic ack_d;
  logic acc;

  assign acc     = rd_i | wr_i;
  assign wait_o  = acc & ~ack_q;
  assign rd_go_o = rd_i & ~ack_q;
  assign wr_go_o = wr_i & ~ack_q;

  always_comb begin
    ack_d = acc & ~ack_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  AST_WAIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wait_o) |=> !wait_o) else $error("wait held too long"); // R1
endmodule

// File: rtl/xcvr_ctl_rstgen.sv
module xcvr_ctl_rstgen #(
  parameter int NUM_CH    = 4,
  parameter int PULSE_CYC = 4,
  parameter bit HAS_PULSE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_i,
  input  logic              hold_i,
  input  logic [NUM_CH-1:0] mask_i,
  output logic [NUM_CH-1:0] rst_o
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  logic stretch;

  generate
    if (HAS_PULSE) begin : g_pulse
      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;

      always_comb begin
        if (cmd_i)             cnt_d = CW'(PULSE_CYC);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else                   cnt_d = cnt_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign stretch = (cnt_q != '0);

      AST_CMD_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i |=> stretch) else $error("command not stretched"); // R3
    end else begin : g_hold_only
      assign stretch = 1'b0;
    end
  endgenerate

  assign rst_o = {NUM_CH{stretch | hold_i}} & mask_i;
endmodule

// File: rtl/xcvr_ctl_pcs_ch.sv
module xcvr_ctl_pcs_ch #(
  parameter int BER_W = 6,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ber_inc_i,
  input  logic             err_inc_i,
  input  logic             ber_clr_i,
  input  logic             err_clr_i,
  input  logic             hi_ber_i,
  input  logic             blk_lock_i,
  input  logic             reload_i,
  output logic [BER_W-1:0] ber_cnt_o,
  output logic [ERR_W-1:0] err_cnt_o,
  output logic             lat_hiber_o,
  output logic             lat_lock_o
);
  logic [BER_W-1:0] ber_q, ber_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic             hib_q, hib_d;
  logic             lck_q, lck_d;

  always_comb begin
    if (ber_clr_i)                      ber_d = '0;
    else if (ber_inc_i && ber_q != '1)  ber_d = ber_q + 1'b1;
    else                                ber_d = ber_q;

    if (err_clr_i)                      err_d = '0;
    else if (err_inc_i && err_q != '1)  err_d = err_q + 1'b1;
    else                                err_d = err_q;

    hib_d = reload_i ? hi_ber_i   : (hib_q | hi_ber_i);
    lck_d = reload_i ? blk_lock_i : (lck_q & blk_lock_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ber_q <= '0;
      err_q <= '0;
      hib_q <= 1'b0;
      lck_q <= 1'b0;
    end else begin
      ber_q <= ber_d;
      err_q <= err_d;
      hib_q <= hib_d;
      lck_q <= lck_d;
    end
  end

  assign ber_cnt_o   = ber_q;
  assign err_cnt_o   = err_q;
  assign lat_hiber_o = hib_q;
  assign lat_lock_o  = lck_q;

  AST_ERR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q == '1 && !err_clr_i) |=> err_q == '1) else $error("err wrapped"); // R10
  AST_BER_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ber_q == '1 && !ber_clr_i) |=> ber_q == '1) else $error("ber wrapped"); // R10
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_i && err_inc_i) |=> err_q == '0) else $error("clear lost"); // R10
  AST_HIBER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hi_ber_i |=> hib_q) else $error("hi-ber not latched"); // R9
  AST_LOCK_LOSS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_lock_i |=> !lck_q) else $error("lock loss not latched"); // R9
endmodule

// File: rtl/xcvr_ctl_regs.sv
module xcvr_ctl_regs
  import xcvr_ctl_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int DATA_W    = 32,
  parameter int PULSE_CYC = 4,
  parameter int BER_W     = 6,
  parameter int ERR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [8:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_wait,
  input  logic              tx_ready_i,
  input  logic              rx_ready_i,
  input  logic [NUM_CH-1:0] lock_data_i,
  input  logic [NUM_CH-1:0] lock_ref_i,
  input  logic [NUM_CH-1:0] link_up_i,
  input  logic [NUM_CH-1:0] hi_ber_i,
  input  logic [NUM_CH-1:0] blk_lock_i,
  input  logic [NUM_CH-1:0] txf_full_i,
  input  logic [NUM_CH-1:0] rxf_full_i,
  input  logic [NUM_CH-1:0] sync_err_i,
  input  logic [NUM_CH-1:0] scr_err_i,
  input  logic [NUM_CH-1:0] rx_dready_i,
  input  logic [NUM_CH-1:0] ber_inc_i,
  input  logic [NUM_CH-1:0] err_inc_i,
  output logic [NUM_CH-1:0] loopback_o,
  output logic [NUM_CH-1:0] set_ltd_o,
  output logic [NUM_CH-1:0] set_ltr_o,
  output logic [NUM_CH-1:0] tx_dig_rst_o,
  output logic [NUM_CH-1:0] rx_ana_rst_o,
  output logic [NUM_CH-1:0] rx_dig_rst_o
);
  localparam int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int LAT_HB = BER_W + ERR_W;
  localparam int LAT_LK = BER_W + ERR_W + 1;

  logic rd_go, wr_go;

  xcvr_ctl_bus u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_i    (cfg_rd),
    .wr_i    (cfg_wr),
    .wait_o  (cfg_wait),
    .rd_go_o (rd_go),
    .wr_go_o (wr_go)
  );

  // ---------------- writable state ----------------
  logic [NUM_CH-1:0] mask_q, mask_d;
  logic [NUM_CH-1:0] loop_q, loop_d;
  logic [NUM_CH-1:0] ltd_q, ltd_d;
  logic [NUM_CH-1:0] ltr_q, ltr_d;
  logic [2:0]        hold_q, hold_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [31:0]       rdata_q, rdata_d;
  logic [31:0]       rd_word;

  logic wr_mask, wr_cmd, wr_hold, wr_loop, wr_ltd, wr_ltr, wr_sel, wr_clr;
  logic tx_cmd, rx_cmd;
  logic sel_ok;

  assign wr_mask = wr_go && (cfg_addr == A_MASK);
  assign wr_cmd  = wr_go && (cfg_addr == A_RST_CMD);
  assign wr_hold = wr_go && (cfg_addr == A_RST_HOLD);
  assign wr_loop = wr_go && (cfg_addr == A_LOOP);
  assign wr_ltd  = wr_go && (cfg_addr == A_LTD);
  assign wr_ltr  = wr_go && (cfg_addr == A_LTR);
  assign wr_sel  = wr_go && (cfg_addr == A_CH_SEL);
  assign wr_clr  = wr_go && (cfg_addr == A_CNT_CLR);

  assign tx_cmd = wr_cmd && cfg_wdata[0];
  assign rx_cmd = wr_cmd && cfg_wdata[1];
  assign sel_ok = (int'(sel_q) < NUM_CH);

  always_comb begin
    mask_d  = wr_mask ? cfg_wdata[NUM_CH-1:0] : mask_q;
    loop_d  = wr_loop ? cfg_wdata[NUM_CH-1:0] : loop_q;
    ltd_d   = wr_ltd  ? cfg_wdata[NUM_CH-1:0] : ltd_q;
    ltr_d   = wr_ltr  ? cfg_wdata[NUM_CH-1:0] : ltr_q;
    hold_d  = wr_hold ? {cfg_wdata[HB_RXD], cfg_wdata[HB_RXA], cfg_wdata[HB_TXD]} : hold_q;
    sel_d   = wr_sel  ? cfg_wdata[SEL_W-1:0] : sel_q;
    rdata_d = rd_go   ? rd_word : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      loop_q  <= '0;
      ltd_q   <= '0;
      ltr_q   <= '0;
      hold_q  <= '0;
      sel_q   <= '0;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_d;
      loop_q  <= loop_d;
      ltd_q   <= ltd_d;
      ltr_q   <= ltr_d;
      hold_q  <= hold_d;
      sel_q   <= sel_d;
      rdata_q <= rdata_d;
    end
  end

  assign loopback_o = loop_q;
  assign set_ltd_o  = ltd_q;
  assign set_ltr_o  = ltr_q;
  assign cfg_rdata  = rdata_q;

  // ---------------- reset outputs ----------------
  xcvr_ctl_rstgen #(.NUM_CH(NUM_CH), .PULSE_CYC(PULSE_CYC), .HAS_PULSE(1'b1)) u_txd (
    .clk(clk), .rst_n(rst_n), .cmd_i(tx_cmd), .hold_i(hold_q[0]),
    .mask_i(mask_q), .rst_o(tx_dig_rst_o));

  xcvr_ctl_rstgen #(.NUM_CH(NUM_CH), .PULSE_CYC(PULSE_CYC), .HAS_PULSE(1'b0)) u_rxa (
    .clk(clk), .rst_n(rst_n), .cmd_i(1'b0), .hold_i(hold_q[1]),
    .mask_i(mask_q), .rst_o(rx_ana_rst_o));

  xcvr_ctl_rstgen #(.NUM_CH(NUM_CH), .PULSE_CYC(PULSE_CYC), .HAS_PULSE(1'b1)) u_rxd (
    .clk(clk), .rst_n(rst_n), .cmd_i(rx_cmd), .hold_i(hold_q[2]),
    .mask_i(mask_q), .rst_o(rx_dig_rst_o));

  // ---------------- per-channel PCS counters ----------------
  logic [NUM_CH-1:0][BER_W-1:0] ber_cnt;
  logic [NUM_CH-1:0][ERR_W-1:0] err_cnt;
  logic [NUM_CH-1:0]            lat_hib;
  logic [NUM_CH-1:0]            lat_lck;
  logic                         rd_cnt;

  assign rd_cnt = rd_go && (cfg_addr == A_PCS_CNT);

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic hit;
      assign hit = (int'(sel_q) == ch);
      xcvr_ctl_pcs_ch #(.BER_W(BER_W), .ERR_W(ERR_W)) u_pcs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ber_inc_i   (ber_inc_i[ch]),
        .err_inc_i   (err_inc_i[ch]),
        .ber_clr_i   (wr_clr && hit && cfg_wdata[CB_BER]),
        .err_clr_i   (wr_clr && hit && cfg_wdata[CB_ERR]),
        .hi_ber_i    (hi_ber_i[ch]),
        .blk_lock_i  (blk_lock_i[ch]),
        .reload_i    (rd_cnt && hit),
        .ber_cnt_o   (ber_cnt[ch]),
        .err_cnt_o   (err_cnt[ch]),
        .lat_hiber_o (lat_hib[ch]),
        .lat_lock_o  (lat_lck[ch])
      );
    end
  endgenerate

  // ---------------- read mux ----------------
  always_comb begin
    rd_word = '0;
    unique case (cfg_addr)
      A_MASK:     rd_word[NUM_CH-1:0] = mask_q;
      A_RST_CMD:  rd_word[1:0] = {rx_ready_i, tx_ready_i};
      A_RST_HOLD: rd_word[3:1] = hold_q;
      A_LOOP:     rd_word[NUM_CH-1:0] = loop_q;
      A_LTD:      rd_word[NUM_CH-1:0] = ltd_q;
      A_LTR:      rd_word[NUM_CH-1:0] = ltr_q;
      A_LTD_ST:   rd_word[NUM_CH-1:0] = lock_data_i;
      A_LTR_ST:   rd_word[NUM_CH-1:0] = lock_ref_i;
      A_PCS_ST: if (sel_ok) begin
        rd_word[7:0] = {rx_dready_i[sel_q], scr_err_i[sel_q], sync_err_i[sel_q],
                        rxf_full_i[sel_q], txf_full_i[sel_q], blk_lock_i[sel_q],
                        hi_ber_i[sel_q], link_up_i[sel_q]};
      end
      A_PCS_CNT: if (sel_ok) begin
        rd_word[BER_W-1:0]           = ber_cnt[sel_q];
        rd_word[BER_W+ERR_W-1:BER_W] = err_cnt[sel_q];
        rd_word[LAT_HB]              = lat_hib[sel_q];
        rd_word[LAT_LK]              = lat_lck[sel_q];
      end
      default:    rd_word = '0;
    endcase
  end

  AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cmd || rx_cmd) |=> !(tx_cmd || rx_cmd)) else $error("command stuck"); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && (cfg_addr < A_MASK)) |=> (cfg_rdata == '0)) else $error("unmapped data"); // R11
  AST_HOLD_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && cfg_addr == A_RST_HOLD) |=> (cfg_rdata[31:4] == '0 && !cfg_rdata[0]))
    else $error("reserved bit set"); // R5
endmodule

// File: tb/xcvr_ctl_regs_tb.sv
module xcvr_ctl_regs_tb;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [31:0] cfg_rdata;
  logic        cfg_wait;
  logic        tx_ready_i = 1'b1, rx_ready_i = 1'b0;
  logic [NCH-1:0] lock_data_i = 4'h6, lock_ref_i = 4'h9;
  logic [NCH-1:0] link_up_i = '0, hi_ber_i = '0, blk_lock_i = '0, txf_full_i = '0;
  logic [NCH-1:0] rxf_full_i = '0, sync_err_i = '0, scr_err_i = '0, rx_dready_i = '0;
  logic [NCH-1:0] ber_inc_i = '0, err_inc_i = '0;
  logic [NCH-1:0] loopback_o, set_ltd_o, set_ltr_o, tx_dig_rst_o, rx_ana_rst_o, rx_dig_rst_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk; // 50 MHz

  xcvr_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata), .cfg_wait(cfg_wait),
    .tx_ready_i(tx_ready_i), .rx_ready_i(rx_ready_i),
    .lock_data_i(lock_data_i), .lock_ref_i(lock_ref_i),
    .link_up_i(link_up_i), .hi_ber_i(hi_ber_i), .blk_lock_i(blk_lock_i),
    .txf_full_i(txf_full_i), .rxf_full_i(rxf_full_i), .sync_err_i(sync_err_i),
    .scr_err_i(scr_err_i), .rx_dready_i(rx_dready_i),
    .ber_inc_i(ber_inc_i), .err_inc_i(err_inc_i),
    .loopback_o(loopback_o), .set_ltd_o(set_ltd_o), .set_ltr_o(set_ltr_o),
    .tx_dig_rst_o(tx_dig_rst_o), .rx_ana_rst_o(rx_ana_rst_o), .rx_dig_rst_o(rx_dig_rst_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access: strobe at a falling edge, accepted at the next rising edge,
  // data sampled at the following falling edge, strobe dropped one cycle later
  task automatic access(input logic wr, input logic [8:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = wr; cfg_rd = ~wr;
    #1 chk("R1 wait first cycle", {31'b0, cfg_wait}, 32'd1);
    @(negedge clk);
    chk("R1 wait second cycle", {31'b0, cfg_wait}, 32'd0);
    rd = cfg_rdata;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_rd = 1'b0;
  endtask

  task automatic wr32(input logic [8:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    access(1'b1, a, d, dummy);
  endtask

  task automatic rd32(input logic [8:0] a, output logic [31:0] d);
    access(1'b0, a, d, d);
  endtask

  typedef struct packed {
    logic        wr;
    logic [8:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1, 9'h041, 32'h0000_0005, 32'h0},          // R2 mask write
    '{1'b0, 9'h041, 32'h0,         32'h0000_0005},  // R2 readback
    '{1'b1, 9'h041, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 9'h041, 32'h0,         32'h0000_000F},  // R2 width
    '{1'b1, 9'h061, 32'h0000_000A, 32'h0},          // R7 loopback
    '{1'b0, 9'h061, 32'h0,         32'h0000_000A},
    '{1'b1, 9'h064, 32'h0000_0003, 32'h0},          // R7 lock-to-data
    '{1'b0, 9'h064, 32'h0,         32'h0000_0003},
    '{1'b1, 9'h065, 32'h0000_000C, 32'h0},          // R7 lock-to-ref
    '{1'b0, 9'h065, 32'h0,         32'h0000_000C},
    '{1'b0, 9'h066, 32'h0,         32'h0000_0006},  // R7 status
    '{1'b1, 9'h066, 32'h0000_000F, 32'h0},          // R7 write ignored
    '{1'b0, 9'h066, 32'h0,         32'h0000_0006},
    '{1'b0, 9'h067, 32'h0,         32'h0000_0009},
    '{1'b1, 9'h044, 32'hFFFF_FFFF, 32'h0},          // R5 reserved bits
    '{1'b0, 9'h044, 32'h0,         32'h0000_000E},
    '{1'b1, 9'h044, 32'h0,         32'h0},
    '{1'b0, 9'h044, 32'h0,         32'h0},
    '{1'b0, 9'h042, 32'h0,         32'h0000_0001},  // R4 tx ready only
    '{1'b1, 9'h080, 32'h0000_0002, 32'h0},          // R8 selector
    '{1'b0, 9'h080, 32'h0,         32'h0},          // R8 write-only
    '{1'b1, 9'h1FF, 32'h1234_5678, 32'h0},          // R11 unmapped
    '{1'b0, 9'h1FF, 32'h0,         32'h0},
    '{1'b1, 9'h000, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 9'h000, 32'h0,         32'h0},
    '{1'b0, 9'h041, 32'h0,         32'h0000_000F}   // R11 mask untouched
  };

  initial begin : wdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // reset state
    chk("R1 wait idle in reset", {31'b0, cfg_wait}, 32'd0);
    chk("R6 tx reset idle", {28'b0, tx_dig_rst_o}, 32'h0);
    chk("R7 loopback reset", {28'b0, loopback_o}, 32'h0);
    rst_n = 1'b1;
    rd32(9'h041, r); chk("R2 mask reset all ones", r, 32'hF);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr32(VECS[i].addr, VECS[i].data);
      else begin
        rd32(VECS[i].addr, r);
        chk($sformatf("vector %0d (see R-tag comment)", i), r, VECS[i].exp);
      end
    end
    chk("R7 loopback pin", {28'b0, loopback_o}, 32'hA);
    chk("R7 ltd pin", {28'b0, set_ltd_o}, 32'h3);
    chk("R7 ltr pin", {28'b0, set_ltr_o}, 32'hC);

    // R6 held resets gated by mask
    wr32(9'h041, 32'h5);
    wr32(9'h044, 32'h2);
    chk("R6 held tx gated", {28'b0, tx_dig_rst_o}, 32'h5);
    chk("R6 rx digital idle", {28'b0, rx_dig_rst_o}, 32'h0);
    wr32(9'h044, 32'h4);
    chk("R6 held rx analog", {28'b0, rx_ana_rst_o}, 32'h5);
    chk("R5 tx hold released", {28'b0, tx_dig_rst_o}, 32'h0);
    wr32(9'h041, 32'hF);
    chk("R6 mask change immediate", {28'b0, rx_ana_rst_o}, 32'hF);
    wr32(9'h044, 32'h0);
    chk("R5 analog released", {28'b0, rx_ana_rst_o}, 32'h0);

    // R3 pulses
    wr32(9'h041, 32'h3);
    wr32(9'h042, 32'h1);
    chk("R3 tx pulse on", {28'b0, tx_dig_rst_o}, 32'h3);
    chk("R3 rx untouched", {28'b0, rx_dig_rst_o}, 32'h0);
    repeat (2) @(negedge clk);
    chk("R3 tx pulse last cycle", {28'b0, tx_dig_rst_o}, 32'h3);
    @(negedge clk);
    chk("R3 tx pulse ended", {28'b0, tx_dig_rst_o}, 32'h0);
    wr32(9'h042, 32'h2);
    chk("R3 rx pulse on", {28'b0, rx_dig_rst_o}, 32'h3);
    chk("R3 tx stays off", {28'b0, tx_dig_rst_o}, 32'h0);
    rx_ready_i = 1'b1; tx_ready_i = 1'b0;
    rd32(9'h042, r); chk("R4 status not command", r, 32'h2);
    wr32(9'h041, 32'hF);

    // R8 status word
    link_up_i = 4'b0100; blk_lock_i = 4'b0100; rxf_full_i = 4'b0100;
    scr_err_i = 4'b0100; rx_dready_i = 4'b0100; hi_ber_i = 4'b0010; txf_full_i = 4'b0010;
    wr32(9'h080, 32'h2);
    rd32(9'h082, r); chk("R8 status ch2", r, 32'hD5);
    wr32(9'h080, 32'h1);
    rd32(9'h082, r); chk("R8 status ch1", r, 32'h0A);
    hi_ber_i = '0; txf_full_i = '0;

    // R9 sticky flags on ch3
    wr32(9'h080, 32'h3);
    rd32(9'h083, r); chk("R9 flags reset", r, 32'h0);
    blk_lock_i[3] = 1'b1;
    rd32(9'h083, r); chk("R9 lock before reload", r, 32'h0);
    rd32(9'h083, r); chk("R9 lock after reload", r, 32'h8000);
    @(negedge clk); hi_ber_i[3] = 1'b1;
    @(negedge clk); hi_ber_i[3] = 1'b0;
    rd32(9'h083, r); chk("R9 hi-ber caught", r, 32'hC000);
    rd32(9'h083, r); chk("R9 hi-ber rearmed", r, 32'h8000);
    @(negedge clk); blk_lock_i[3] = 1'b0;
    @(negedge clk); blk_lock_i[3] = 1'b1;
    rd32(9'h083, r); chk("R9 lock loss caught", r, 32'h0);
    rd32(9'h083, r); chk("R9 lock rearmed", r, 32'h8000);

    // R10 counters on ch3
    @(negedge clk); ber_inc_i[3] = 1'b1;
    repeat (70) @(negedge clk);
    ber_inc_i[3] = 1'b0;
    rd32(9'h083, r); chk("R10 ber saturates", r, 32'h803F);
    err_inc_i[3] = 1'b1;
    repeat (300) @(negedge clk);
    err_inc_i[3] = 1'b0;
    rd32(9'h083, r); chk("R10 err saturates", r, 32'hBFFF);
    err_inc_i[3] = 1'b1;
    wr32(9'h081, 32'h4);
    err_inc_i[3] = 1'b0;
    rd32(9'h083, r); chk("R10 clear beats increment", r, 32'h807F);
    wr32(9'h081, 32'h8);
    rd32(9'h083, r); chk("R10 ber cleared", r, 32'h8040);
    rd32(9'h081, r); chk("R10 clear word reads 0", r, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule